// File: doc/BRIEF.md
# Persistent Source/Destination Port Router

This block sits between a 16-bit host data bus and the wide internal resources of an associative memory device. Each bus cycle is classified by three control inputs as either a command cycle or a data cycle, and as a read or a write. Data cycles move one 16-bit segment of a 64-bit resource. The resource that data reads come from and the resource that data writes go to are chosen separately by two select instructions. Each choice stays in force until the next instruction of the same kind. After reset both point at the comparand register.

Command writes go to the instruction decoder and command reads return the status word. The exceptions are the select instructions and a temporary override instruction. An override arms a one-shot path to one auxiliary register: control, page address, segment control, address, next-free or device select. It can also arm a readback of the current source or destination selection. The next command cycle, read or write, uses that path, and routing then falls back to the defaults. A segment counter steps through a programmable window of segments on every data cycle.

A two-state machine holds the override: ST_DEFAULT and ST_OVERRIDE. The transition ARM (ST_DEFAULT to ST_OVERRIDE) is taken on a command write that carries an override instruction. The transition CONSUME (ST_OVERRIDE to ST_DEFAULT) is taken on any command cycle. In every other case the state holds: HOLD_DEFAULT in ST_DEFAULT, and HOLD_OVERRIDE on data or idle cycles in ST_OVERRIDE.

Top module: `psd_port_router`

## Requirements
- R1: After reset, the data source and the data destination are both the comparand. The segment counter is 0 and the segment control register reads 0x000C, which selects a window from segment 0 to segment 3. All resources and auxiliary registers other than segment control are zero, and no override is armed.
- R2: A data write (valid, command low, write high) stores din into the current segment of the persistent destination. Segment s occupies bits 16s+15 to 16s. A data read drives the current segment of the persistent source on dout in the same cycle. dout is zero in every cycle that is not a read.
- R3: A command word with opcode 0x1 in bits 15:12 selects the data source, and opcode 0x2 selects the data destination. Bits 1:0 carry the resource code: 0 comparand, 1 mask one, 2 mask two, 3 memory row. The two selections are independent, and each holds until the next instruction of its own kind.
- R4: Each data cycle moves the segment counter from s to s+1 modulo 4. When s equals the end field (bits 3:2 of segment control), the counter moves to the start field (bits 1:0) instead. Command and idle cycles leave the counter unchanged.
- R5: In ST_DEFAULT, a command read returns status_in on dout.
- R6: In ST_DEFAULT, a command write whose opcode is not 0x1, 0x2 or 0x3 raises instr_strobe for that cycle, and instr_word carries the word. Select and override words never raise instr_strobe.
- R7: A command word with opcode 0x3 arms an override. Bits 2:0 give the target: 0 control, 1 page, 2 segment control, 3 address, 4 next-free, 5 device select, 6 source readback, 7 destination readback. Exactly the next command cycle uses the target: a write loads the register, and a read returns it. That command write is not decoded as an instruction. Data cycles do not consume the override.
- R8: Readback targets 6 and 7 return the current source or destination code in bits 1:0, with the upper bits zero. Writes to these two targets change nothing.
- R9: The memory row is selected by the low 4 bits of the address register.
- R10: A write to segment control reloads the segment counter with the new start field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A bus cycle is present this clock |
| cyc_write | input | 1 | 1 write cycle, 0 read cycle |
| cyc_cmd | input | 1 | 1 command cycle, 0 data cycle |
| din | input | 16 | Host write data or command word |
| status_in | input | 16 | Status word from the compare engine |
| dout | output | 16 | Read data, zero when no read is present |
| instr_strobe | output | 1 | Forwarded instruction valid |
| instr_word | output | 16 | Forwarded instruction word |

## Verification
The routing is tried with long runs of data writes followed by reads on each of the four resources. Source and destination are deliberately set to different resources, which separates a router that honours the two selections independently from one that shares a single selection. Two segment windows are used: a forward window and one that wraps past segment 3 back through 0. Both are entered through the override path, which shows whether the reload and the end-to-start return happen in the right cycle. The override is also interleaved with data cycles and with words that look like select instructions, which tells a one-shot that only command cycles consume apart from one that expires early or decodes its payload. A bench model predicts dout and instr_strobe on every clock.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam logic [3:0] OP_SEL_SRC = 4'h1;
    localparam logic [3:0] OP_SEL_DST = 4'h2;
    localparam logic [3:0] OP_OVR     = 4'h3;

    typedef enum logic [1:0] {
        RES_CMP  = 2'd0,
        RES_MSK1 = 2'd1,
        RES_MSK2 = 2'd2,
        RES_MEM  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        AUX_CTRL   = 3'd0,
        AUX_PAGE   = 3'd1,
        AUX_SEGCTL = 3'd2,
        AUX_ADDR   = 3'd3,
        AUX_NFREE  = 3'd4,
        AUX_DSEL   = 3'd5,
        AUX_PS     = 3'd6,
        AUX_PD     = 3'd7
    } aux_e;

    typedef enum logic {
        ST_DEFAULT  = 1'b0,
        ST_OVERRIDE = 1'b1
    } rt_state_e;

    typedef struct packed {
        logic sel_src;
        logic sel_dst;
        logic ovr;
        logic fwd;
        res_e res;
        aux_e aux;
    } dec_t;

endpackage

// File: rtl/psr_decode.sv
module psr_decode
    import psr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    output dec_t              dec
);

    logic [3:0] op;
    logic       unused_bits;

    assign op          = word[DATA_W-1 -: 4];
    assign unused_bits = ^word[DATA_W-5:3];

    always_comb begin
        dec         = '0;
        dec.sel_src = (op == OP_SEL_SRC);
        dec.sel_dst = (op == OP_SEL_DST);
        dec.ovr     = (op == OP_OVR);
        dec.fwd     = !(dec.sel_src || dec.sel_dst || dec.ovr);
        dec.res     = res_e'(word[1:0]);
        dec.aux     = aux_e'(word[2:0]);
    end

endmodule

// File: rtl/psr_seg_counter.sv
module psr_seg_counter #(
    parameter int SEG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEG_W-1:0] load_start,
    input  logic [SEG_W-1:0] cfg_start,
    input  logic [SEG_W-1:0] cfg_end,
    input  logic             step,
    output logic [SEG_W-1:0] seg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg <= '0;
        end else if (load) begin
            seg <= load_start;
        end else if (step) begin
            if (seg == cfg_end) begin
                seg <= cfg_start;
            end else begin
                seg <= seg + 1'b1;
            end
        end
    end

    // R4: return to start after the end segment
    a_r4_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && seg == cfg_end) |=> (seg == $past(cfg_start)));

    // R4: plain advance inside the window
    a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && seg != cfg_end) |=> (seg == $past(seg) + 1'b1));

    // R4: no movement without a data cycle or reload
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(seg));

    // R10: reload takes the new start field
    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (seg == $past(load_start)));

endmodule

// File: rtl/psr_resource_bank.sv
module psr_resource_bank #(
    parameter int DATA_W    = 16,
    parameter int SEG_CNT   = 4,
    parameter int MEM_DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_res,
    input  logic [$clog2(SEG_CNT)-1:0]   wr_seg,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [$clog2(MEM_DEPTH)-1:0] row,
    input  logic [1:0]                   rd_res,
    input  logic [$clog2(SEG_CNT)-1:0]   rd_seg,
    output logic [DATA_W-1:0]            rd_data
);

    localparam int RES_W  = DATA_W * SEG_CNT;
    localparam int N_REGS = 3;

    logic [3:0][RES_W-1:0]           res_q;
    logic [MEM_DEPTH-1:0][RES_W-1:0] mem_q;

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic [RES_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_res == 2'(g)) begin
                q[wr_seg*DATA_W +: DATA_W] <= wr_data;
            end
        end
        assign res_q[g] = q;
    end

    for (genvar r = 0; r < MEM_DEPTH; r++) begin : g_row
        logic [RES_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_res == 2'd3 && row == ($clog2(MEM_DEPTH))'(r)) begin
                q[wr_seg*DATA_W +: DATA_W] <= wr_data;
            end
        end
        assign mem_q[r] = q;
    end

    assign res_q[3] = mem_q[row];
    assign rd_data  = res_q[rd_res][rd_seg*DATA_W +: DATA_W];

endmodule

// File: rtl/psd_port_router.sv
module psd_port_router
    import psr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SEG_CNT   = 4,
    parameter int MEM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic              cyc_cmd,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] dout,
    output logic              instr_strobe,
    output logic [DATA_W-1:0] instr_word
);

    localparam int SEG_W  = $clog2(SEG_CNT);
    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int N_AUX  = 6;
    localparam logic [DATA_W-1:0] SEGCTL_RST = DATA_W'(SEG_CNT - 1) << SEG_W;

    rt_state_e state, state_nx;
    aux_e      ovr_tgt;
    res_e      src_sel, dst_sel;
    dec_t      dec;

    logic cmd_wr, cmd_rd, dat_wr, dat_rd;
    logic arm, consume, ovr_wr, seg_load;
    logic [N_AUX-1:0][DATA_W-1:0] aux_q;
    logic [SEG_W-1:0]  seg;
    logic [DATA_W-1:0] bank_rd;

    assign cmd_wr = cyc_valid &&  cyc_cmd &&  cyc_write;
    assign cmd_rd = cyc_valid &&  cyc_cmd && !cyc_write;
    assign dat_wr = cyc_valid && !cyc_cmd &&  cyc_write;
    assign dat_rd = cyc_valid && !cyc_cmd && !cyc_write;

    psr_decode #(.DATA_W(DATA_W)) u_decode (
        .word (din),
        .dec  (dec)
    );

    assign arm      = (state == ST_DEFAULT) && cmd_wr && dec.ovr;
    assign consume  = (state == ST_OVERRIDE) && (cmd_wr || cmd_rd);
    assign ovr_wr   = (state == ST_OVERRIDE) && cmd_wr;
    assign seg_load = ovr_wr && (ovr_tgt == AUX_SEGCTL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DEFAULT;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: ARM, CONSUME, HOLD_DEFAULT, HOLD_OVERRIDE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DEFAULT:  if (arm)     state_nx = ST_OVERRIDE;
            ST_OVERRIDE: if (consume) state_nx = ST_DEFAULT;
        endcase
    end

    // persistent selections and override target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel <= RES_CMP;
            dst_sel <= RES_CMP;
            ovr_tgt <= AUX_CTRL;
        end else if (state == ST_DEFAULT && cmd_wr) begin
            if (dec.sel_src) src_sel <= dec.res;
            if (dec.sel_dst) dst_sel <= dec.res;
            if (dec.ovr)     ovr_tgt <= dec.aux;
        end
    end

    // auxiliary registers, written only through the override path
    for (genvar a = 0; a < N_AUX; a++) begin : g_aux
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                aux_q[a] <= (a == int'(AUX_SEGCTL)) ? SEGCTL_RST : '0;
            end else if (ovr_wr && ovr_tgt == 3'(a)) begin
                aux_q[a] <= din;
            end
        end
    end

    psr_seg_counter #(.SEG_W(SEG_W)) u_seg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (seg_load),
        .load_start (din[SEG_W-1:0]),
        .cfg_start  (aux_q[AUX_SEGCTL][SEG_W-1:0]),
        .cfg_end    (aux_q[AUX_SEGCTL][2*SEG_W-1:SEG_W]),
        .step       (dat_wr || dat_rd),
        .seg        (seg)
    );

    psr_resource_bank #(
        .DATA_W    (DATA_W),
        .SEG_CNT   (SEG_CNT),
        .MEM_DEPTH (MEM_DEPTH)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dat_wr),
        .wr_res  (dst_sel),
        .wr_seg  (seg),
        .wr_data (din),
        .row     (aux_q[AUX_ADDR][ADDR_W-1:0]),
        .rd_res  (src_sel),
        .rd_seg  (seg),
        .rd_data (bank_rd)
    );

    // outputs
    always_comb begin
        dout         = '0;
        instr_strobe = 1'b0;
        instr_word   = '0;
        if (dat_rd) begin
            dout = bank_rd;
        end else if (cmd_rd) begin
            unique case (state)
                ST_DEFAULT:  dout = status_in;
                ST_OVERRIDE: begin
                    unique case (ovr_tgt)
                        AUX_CTRL:   dout = aux_q[0];
                        AUX_PAGE:   dout = aux_q[1];
                        AUX_SEGCTL: dout = aux_q[2];
                        AUX_ADDR:   dout = aux_q[3];
                        AUX_NFREE:  dout = aux_q[4];
                        AUX_DSEL:   dout = aux_q[5];
                        AUX_PS:     dout = DATA_W'(src_sel);
                        AUX_PD:     dout = DATA_W'(dst_sel);
                    endcase
                end
            endcase
        end
        if (state == ST_DEFAULT && cmd_wr && dec.fwd) begin
            instr_strobe = 1'b1;
            instr_word   = din;
        end
    end

    // R7: any command cycle ends the override
    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVERRIDE && cyc_valid && cyc_cmd) |=> (state == ST_DEFAULT));

    // R7: data cycles leave the override armed
    a_r7_data_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVERRIDE && !(cyc_valid && cyc_cmd)) |=> (state == ST_OVERRIDE));

    // R3: the source selection is sticky
    a_r3_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_DEFAULT && cmd_wr && din[DATA_W-1 -: 4] == OP_SEL_SRC) |=> $stable(src_sel));

    // R3: the destination selection is sticky
    a_r3_dst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_DEFAULT && cmd_wr && din[DATA_W-1 -: 4] == OP_SEL_DST) |=> $stable(dst_sel));

    // R5: default command reads return status
    a_r5_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEFAULT && cyc_valid && cyc_cmd && !cyc_write) |-> (dout == status_in));

    // R6: forwarding only from a default command write
    a_r6_fwd_default: assert property (@(posedge clk) disable iff (!rst_n)
        instr_strobe |-> (state == ST_DEFAULT && cyc_valid && cyc_cmd && cyc_write));

    // R2: output quiet when no read is present
    a_r2_quiet_dout: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_valid && !cyc_write) |-> (dout == '0));

endmodule

// File: tb/psd_port_router_tb.sv
module psd_port_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0, cyc_write = 1'b0, cyc_cmd = 1'b0;
    logic [15:0] din = '0, status_in = '0;
    logic [15:0] dout, instr_word;
    logic        instr_strobe;

    always #5 clk = ~clk;

    psd_port_router u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .cyc_cmd(cyc_cmd), .din(din), .status_in(status_in), .dout(dout),
        .instr_strobe(instr_strobe), .instr_word(instr_word)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model
    logic [63:0] m_res[4];
    logic [63:0] m_mem[16];
    int  m_aux[6];
    int  m_src, m_dst, m_seg, m_tgt;
    bit  m_armed;

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] src_word();
        if (m_src == 3) return m_mem[m_aux[3] & 15];
        return m_res[m_src];
    endfunction

    function automatic void seg_step();
        int st = m_aux[2] & 3;
        int en = (m_aux[2] >> 2) & 3;
        if (m_seg == en) m_seg = st;
        else m_seg = (m_seg + 1) % 4;
    endfunction

    task automatic cyc(bit v, bit w, bit c, logic [15:0] d, string tag);
        logic [15:0] e_dout;
        logic        e_stb;
        logic [63:0] wd;
        int          op;
        @(negedge clk);
        cyc_valid = v; cyc_write = w; cyc_cmd = c; din = d;
        #1;
        op     = int'(d[15:12]);
        e_dout = '0;
        e_stb  = 1'b0;
        if (v && !w && !c) begin
            wd = src_word();
            e_dout = wd[m_seg*16 +: 16];
        end else if (v && !w && c) begin
            if (!m_armed)        e_dout = status_in;
            else if (m_tgt < 6)  e_dout = 16'(m_aux[m_tgt]);
            else if (m_tgt == 6) e_dout = 16'(m_src);
            else                 e_dout = 16'(m_dst);
        end
        if (v && w && c && !m_armed && !(op >= 1 && op <= 3)) e_stb = 1'b1;
        check(tag, "dout", dout, e_dout);
        check(tag, "instr_strobe", {15'd0, instr_strobe}, {15'd0, e_stb});
        check(tag, "instr_word", instr_word, e_stb ? d : 16'h0);
        // advance model to the state after this edge
        if (v && !c) begin
            if (w) begin
                if (m_dst == 3) m_mem[m_aux[3] & 15][m_seg*16 +: 16] = d;
                else            m_res[m_dst][m_seg*16 +: 16] = d;
            end
            seg_step();
        end else if (v && c) begin
            if (m_armed) begin
                if (w && m_tgt < 6) begin
                    m_aux[m_tgt] = int'(d);
                    if (m_tgt == 2) m_seg = int'(d[1:0]);
                end
                m_armed = 0;
            end else if (w) begin
                if (op == 1) m_src = int'(d[1:0]);
                if (op == 2) m_dst = int'(d[1:0]);
                if (op == 3) begin m_armed = 1; m_tgt = int'(d[2:0]); end
            end
        end
    endtask

    task automatic dwr(logic [15:0] d, string tag); cyc(1, 1, 0, d, tag); endtask
    task automatic drd(string tag);                 cyc(1, 0, 0, 16'h0, tag); endtask
    task automatic cwr(logic [15:0] d, string tag); cyc(1, 1, 1, d, tag); endtask
    task automatic crd(string tag);                 cyc(1, 0, 1, 16'h0, tag); endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++)  m_res[i] = '0;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        for (int i = 0; i < 6; i++)  m_aux[i] = 0;
        m_aux[2] = 16'h000C;
        m_src = 0; m_dst = 0; m_seg = 0; m_tgt = 0; m_armed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cyc(0, 0, 0, 16'h0, "R1");
        drd("R1");
        cwr(16'h3002, "R1"); crd("R1");
        cwr(16'h3006, "R1"); crd("R1");
        cwr(16'h3007, "R1"); crd("R1");

        // R5: status reads
        status_in = 16'hA5C3; crd("R5");
        status_in = 16'h0F0F; crd("R5");

        // R2: comparand segments
        for (int i = 0; i < 4; i++) dwr(16'h1100 + 16'(i), "R2");
        for (int i = 0; i < 5; i++) drd("R2");

        // R3: mask one as destination, comparand still the source
        cwr(16'h2001, "R3");
        for (int i = 0; i < 4; i++) dwr(16'h2200 + 16'(i), "R3");
        for (int i = 0; i < 4; i++) drd("R3");
        cwr(16'h1001, "R3");
        for (int i = 0; i < 4; i++) drd("R3");
        cwr(16'h2002, "R3");
        dwr(16'hBEEF, "R3");
        cwr(16'h1002, "R3");
        for (int i = 0; i < 4; i++) drd("R3");

        // R8: selection readback, writes to readback ignored
        cwr(16'h3006, "R8"); crd("R8");
        cwr(16'h3007, "R8"); crd("R8");
        cwr(16'h3006, "R8"); cwr(16'h0003, "R8");
        cwr(16'h3006, "R8"); crd("R8");

        // R9: memory rows via the address register
        cwr(16'h3003, "R9"); cwr(16'h0005, "R9");
        cwr(16'h2003, "R9"); cwr(16'h1003, "R9");
        for (int i = 0; i < 4; i++) dwr(16'h5500 + 16'(i), "R9");
        cwr(16'h3003, "R9"); cwr(16'h0016, "R9");
        for (int i = 0; i < 4; i++) drd("R9");
        cwr(16'h3003, "R9"); cwr(16'h0005, "R9");
        for (int i = 0; i < 4; i++) drd("R9");

        // R10 and R4: window 1..2, then 3 wrapping to 1
        cwr(16'h3002, "R10"); cwr(16'h0009, "R10");
        for (int i = 0; i < 5; i++) drd("R4");
        cwr(16'h3002, "R10"); cwr(16'h0007, "R10");
        for (int i = 0; i < 3; i++) dwr(16'h7700 + 16'(i), "R4");
        for (int i = 0; i < 7; i++) drd("R4");
        crd("R4");
        cyc(0, 1, 0, 16'h0, "R4");
        drd("R4");
        cwr(16'h3002, "R10"); cwr(16'h000C, "R10");

        // R6: forwarding
        cwr(16'h5A5A, "R6");
        cwr(16'h0000, "R6");
        cwr(16'hF123, "R6");
        cyc(0, 1, 1, 16'h4444, "R6");

        // R7: one-shot override, data cycles do not consume it
        cwr(16'h3000, "R7");
        drd("R7");
        dwr(16'h9999, "R7");
        cwr(16'h1000, "R7");
        crd("R7");
        cwr(16'h3000, "R7"); crd("R7");
        cwr(16'h3006, "R7"); crd("R7");
        cwr(16'h3001, "R7"); cwr(16'h0042, "R7");
        cwr(16'h3004, "R7"); cwr(16'h0123, "R7");
        cwr(16'h3005, "R7"); cwr(16'hFFFF, "R7");
        cwr(16'h3001, "R7"); crd("R7");
        cwr(16'h3004, "R7"); crd("R7");
        cwr(16'h3005, "R7"); crd("R7");
        crd("R7");
        cwr(16'h3003, "R7"); cwr(16'h3001, "R7");
        cwr(16'h7777, "R7");
        for (int i = 0; i < 4; i++) drd("R2");
        cyc(0, 0, 0, 16'h0, "R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule